// File: doc/BRIEF.md
# Asynchronous Byte-Wide SRAM Cycle Controller

This block turns single-cycle requests from a synchronous host into correctly framed read and write cycles on an external 8192 x 8 asynchronous static RAM. The host offers a request strobe with a read/write flag, a 13-bit address and a write byte. The request is taken when the controller shows it is ready. The controller answers with a one-clock done pulse and, for reads, the captured byte.

On the memory side the controller drives the address bus and three active-low strobes: chip select, write strobe and output strobe. The bidirectional data bus is split into an outgoing byte, an incoming byte and a driver enable, so that the tri-state buffer can sit at the pad. Every timing limit of the memory is a module parameter counted in clock cycles, with a minimum of 1. One down-counter measures the length of each phase.

Top module: `sram_async_ctl`

## Requirements
- R1: During a read the write strobe stays high while chip select and output strobe are both low, and the address bus carries the address of the accepted request.
- R2: Read data is sampled from the memory bus only after RD = max(T_AA, T_CO, T_OE) cycles with chip select and output strobe low. Done follows the accepting edge by exactly RD cycles.
- R3: A write holds chip select low with the write strobe high for T_AS cycles. It then holds both low for PW = max(T_WP, T_DS) cycles, and both rise on the same edge, which closes the write window.
- R4: The address bus stays constant from the accepting edge until the controller returns to ready.
- R5: The output strobe is high whenever the write strobe is low or the controller drives the data bus, so the two drivers never overlap.
- R6: The data driver turns on with the window and carries the same byte throughout it. It is still on during the cycle in which the strobes rise, and it is off in the cycle after that. The byte stored by the memory equals the requested write data.
- R7: After the window closes, the write strobe stays high for at least T_WR + 1 cycles before the next chip select. The done pulse of a write follows the accepting edge by exactly T_AS + PW + 1 + T_WR cycles.
- R8: Ready is low from the accepting edge until the done cycle. A request, address or write byte presented while ready is low starts no cycle and changes no memory byte.
- R9: Done is high for exactly one cycle. After a read, the read-data output holds the sampled byte from the done cycle onward. A write leaves the read-data output unchanged.
- R10: After reset, ready is high, done is low, all three strobes are high and the data driver is off.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| host_req | input | 1 | Request strobe, taken when host_ready is high |
| host_we | input | 1 | 1 = write, 0 = read |
| host_addr | input | 13 | Byte address |
| host_wdata | input | 8 | Byte to write |
| host_ready | output | 1 | Controller idle and able to take a request |
| host_rdata | output | 8 | Last byte read |
| host_done | output | 1 | One-clock completion pulse |
| mem_addr | output | 13 | Memory address bus |
| mem_ce_n | output | 1 | Chip select, active low |
| mem_we_n | output | 1 | Write strobe, active low |
| mem_oe_n | output | 1 | Output strobe, active low |
| mem_dq_out | output | 8 | Byte toward the memory |
| mem_dq_in | input | 8 | Byte from the memory |
| mem_dq_oe | output | 1 | Data driver enable |

## Verification
With the bench parameters, done is due 3 cycles after the accepting edge for a read and 7 cycles after it for a write. The bench counts clock edges from acceptance and samples 1 ns after each edge, so an early or late pulse shows up as a wrong count. The memory model drives a poison byte until the read strobes have been low for RD full cycles, which makes a sample taken one edge early fail the data check. Window length, setup, data stability, driver release and the recovery gap are measured at the falling clock edge, half a cycle away from any change in the outputs.

// File: rtl/sram_ctl_pkg.sv
package sram_ctl_pkg;

  typedef enum logic [2:0] {
    ST_IDLE   = 3'd0,
    ST_READ   = 3'd1,
    ST_WSETUP = 3'd2,
    ST_WPULSE = 3'd3,
    ST_WHOLD  = 3'd4,
    ST_WREC   = 3'd5
  } cyc_state_t;

  function automatic int unsigned max_u(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/sram_rst_sync.sv
module sram_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic stage_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage_q    <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      stage_q    <= 1'b1;
      rst_sync_n <= stage_q;
    end
  end
endmodule

// File: rtl/sram_cyc_timer.sv
module sram_cyc_timer #(
  parameter int unsigned CNT_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic             expired
);
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_d;
  logic             cnt_en;

  always_comb begin
    cnt_en = load || (cnt_q != '0);
    cnt_d  = load ? load_val : (cnt_q - 1'b1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end

  assign expired = (cnt_q == '0);
endmodule

// File: rtl/sram_cyc_datapath.sv
module sram_cyc_datapath #(
  parameter int unsigned ADDR_W = 13,
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              accept,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  input  logic              capture,
  input  logic [DATA_W-1:0] bus_in,
  output logic [ADDR_W-1:0] addr_q,
  output logic [DATA_W-1:0] wdata_q,
  output logic [DATA_W-1:0] rdata_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q  <= '0;
      wdata_q <= '0;
    end else if (accept) begin
      addr_q  <= req_addr;
      wdata_q <= req_wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdata_q <= '0;
    end else if (capture) begin
      rdata_q <= bus_in;
    end
  end
endmodule

// File: rtl/sram_async_ctl.sv
module sram_async_ctl #(
  parameter int unsigned ADDR_W = 13,
  parameter int unsigned DATA_W = 8,
  parameter int unsigned T_AA   = 4,
  parameter int unsigned T_CO   = 4,
  parameter int unsigned T_OE   = 2,
  parameter int unsigned T_AS   = 1,
  parameter int unsigned T_WP   = 3,
  parameter int unsigned T_DS   = 2,
  parameter int unsigned T_WR   = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              host_req,
  input  logic              host_we,
  input  logic [ADDR_W-1:0] host_addr,
  input  logic [DATA_W-1:0] host_wdata,
  output logic              host_ready,
  output logic [DATA_W-1:0] host_rdata,
  output logic              host_done,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              mem_ce_n,
  output logic              mem_we_n,
  output logic              mem_oe_n,
  output logic [DATA_W-1:0] mem_dq_out,
  input  logic [DATA_W-1:0] mem_dq_in,
  output logic              mem_dq_oe
);
  import sram_ctl_pkg::*;

  localparam int unsigned T_RD    = max_u(max_u(T_AA, T_CO), T_OE);
  localparam int unsigned T_PULSE = max_u(T_WP, T_DS);
  localparam int unsigned T_MAX   = max_u(max_u(T_RD, T_PULSE), max_u(T_AS, T_WR));
  localparam int unsigned CNT_W   = $clog2(T_MAX + 1);

  logic             rst_sync_n;
  cyc_state_t       state_q, state_d;
  logic             tmr_load;
  logic [CNT_W-1:0] tmr_val;
  logic             tmr_expired;
  logic             accept;
  logic             capture;
  logic             done_d, done_q;

  sram_rst_sync u_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  sram_cyc_timer #(.CNT_W(CNT_W)) u_timer (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .load     (tmr_load),
    .load_val (tmr_val),
    .expired  (tmr_expired)
  );

  sram_cyc_datapath #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_datapath (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .accept    (accept),
    .req_addr  (host_addr),
    .req_wdata (host_wdata),
    .capture   (capture),
    .bus_in    (mem_dq_in),
    .addr_q    (mem_addr),
    .wdata_q   (mem_dq_out),
    .rdata_q   (host_rdata)
  );

  // Next-state and phase-length selection
  always_comb begin
    state_d  = state_q;
    tmr_load = 1'b0;
    tmr_val  = '0;
    accept   = 1'b0;
    capture  = 1'b0;
    done_d   = 1'b0;
    case (state_q)
      ST_IDLE: begin
        if (host_req) begin
          accept   = 1'b1;
          tmr_load = 1'b1;
          if (host_we) begin
            state_d = ST_WSETUP;
            tmr_val = CNT_W'(T_AS - 1);
          end else begin
            state_d = ST_READ;
            tmr_val = CNT_W'(T_RD - 1);
          end
        end
      end
      ST_READ: begin
        if (tmr_expired) begin
          capture = 1'b1;
          done_d  = 1'b1;
          state_d = ST_IDLE;
        end
      end
      ST_WSETUP: begin
        if (tmr_expired) begin
          state_d  = ST_WPULSE;
          tmr_load = 1'b1;
          tmr_val  = CNT_W'(T_PULSE - 1);
        end
      end
      ST_WPULSE: begin
        if (tmr_expired) begin
          state_d = ST_WHOLD;
        end
      end
      ST_WHOLD: begin
        state_d  = ST_WREC;
        tmr_load = 1'b1;
        tmr_val  = CNT_W'(T_WR - 1);
      end
      ST_WREC: begin
        if (tmr_expired) begin
          done_d  = 1'b1;
          state_d = ST_IDLE;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      state_q <= ST_IDLE;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      done_q  <= done_d;
    end
  end

  // Memory strobes decoded from the phase register
  always_comb begin
    mem_ce_n  = !(state_q == ST_READ || state_q == ST_WSETUP || state_q == ST_WPULSE);
    mem_we_n  = !(state_q == ST_WPULSE);
    mem_oe_n  = !(state_q == ST_READ);
    mem_dq_oe = (state_q == ST_WPULSE) || (state_q == ST_WHOLD);
  end

  assign host_ready = (state_q == ST_IDLE);
  assign host_done  = done_q;

  AST_READ_FRAME: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !mem_oe_n |-> (mem_we_n && !mem_ce_n)); // R1
  AST_READ_DONE_LATENCY: assert property (@(posedge clk) disable iff (!rst_sync_n)
    ($fell(mem_oe_n) && !host_ready) |-> !host_done); // R2
  AST_CE_BEFORE_WE: assert property (@(posedge clk) disable iff (!rst_sync_n)
    $fell(mem_we_n) |-> $past(!mem_ce_n)); // R3
  AST_STROBES_RISE_TOGETHER: assert property (@(posedge clk) disable iff (!rst_sync_n)
    $rose(mem_we_n) |-> $rose(mem_ce_n)); // R3
  AST_ADDR_HELD: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (!host_ready && $past(!host_ready)) |-> $stable(mem_addr)); // R4
  AST_NO_CONTENTION: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (mem_dq_oe || !mem_we_n) |-> mem_oe_n); // R5
  AST_DATA_THRU_RISE: assert property (@(posedge clk) disable iff (!rst_sync_n)
    $rose(mem_we_n) |-> mem_dq_oe); // R6
  AST_DRIVER_RELEASE: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (mem_dq_oe && mem_we_n) |=> !mem_dq_oe); // R6
  AST_DATA_STABLE: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (mem_dq_oe && $past(mem_dq_oe)) |-> $stable(mem_dq_out)); // R6
  AST_READY_AT_DONE: assert property (@(posedge clk) disable iff (!rst_sync_n)
    host_done |-> host_ready); // R8
  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_sync_n)
    host_done |=> !host_done); // R9
endmodule

// File: tb/tb_sram_async_ctl.sv
module tb_sram_async_ctl;
  localparam int unsigned AW = 13;
  localparam int unsigned DW = 8;
  localparam int unsigned P_AA = 3, P_CO = 2, P_OE = 1;
  localparam int unsigned P_AS = 1, P_WP = 2, P_DS = 3, P_WR = 2;
  localparam int unsigned EXP_RD  = 3;
  localparam int unsigned EXP_PW  = 3;
  localparam int unsigned EXP_WLAT = P_AS + EXP_PW + 1 + P_WR;
  localparam int NVEC = 10;
  // {write flag, address, byte}
  localparam logic [21:0] VEC [NVEC] = '{
    {1'b1, 13'h0000, 8'hA5},
    {1'b1, 13'h1FFF, 8'h3C},
    {1'b1, 13'h0AAA, 8'h96},
    {1'b1, 13'h1555, 8'h0F},
    {1'b0, 13'h0000, 8'h00},
    {1'b0, 13'h1FFF, 8'h00},
    {1'b0, 13'h0AAA, 8'h00},
    {1'b1, 13'h0000, 8'hF0},
    {1'b0, 13'h0000, 8'h00},
    {1'b0, 13'h1555, 8'h00}
  };

  logic clk, rst_n;
  logic host_req, host_we, host_ready, host_done;
  logic [AW-1:0] host_addr, mem_addr;
  logic [DW-1:0] host_wdata, host_rdata, mem_dq_out, mem_dq_in;
  logic mem_ce_n, mem_we_n, mem_oe_n, mem_dq_oe;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  logic [DW-1:0] mem_m [int];
  logic [DW-1:0] shadow [int];

  sram_async_ctl #(
    .ADDR_W(AW), .DATA_W(DW), .T_AA(P_AA), .T_CO(P_CO), .T_OE(P_OE),
    .T_AS(P_AS), .T_WP(P_WP), .T_DS(P_DS), .T_WR(P_WR)
  ) dut (
    .clk(clk), .rst_n(rst_n), .host_req(host_req), .host_we(host_we),
    .host_addr(host_addr), .host_wdata(host_wdata), .host_ready(host_ready),
    .host_rdata(host_rdata), .host_done(host_done), .mem_addr(mem_addr),
    .mem_ce_n(mem_ce_n), .mem_we_n(mem_we_n), .mem_oe_n(mem_oe_n),
    .mem_dq_out(mem_dq_out), .mem_dq_in(mem_dq_in), .mem_dq_oe(mem_dq_oe)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic finish_sim();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles == 50000) begin
      errors++;
      $display("FAIL watchdog: actual %0d expected %0d", cycles, 0);
      finish_sim();
    end
  end

  // Memory model: counts full cycles with read strobes low, poisons early reads
  int acc_cnt = 0;
  function automatic logic [DW-1:0] model_rd(input logic [AW-1:0] a);
    if (mem_m.exists(int'(a))) return mem_m[int'(a)];
    return 8'h00;
  endfunction
  assign mem_dq_in = (acc_cnt >= int'(EXP_RD)) ? model_rd(mem_addr) : 8'hEE;

  logic prev_win = 1'b0, prev_close = 1'b0;
  logic [DW-1:0] prev_dq;
  logic [AW-1:0] prev_addr;
  int win_len = 0, setup_len = 0, rec_len = 0;
  bit rec_active = 0;
  bit mon_en = 0;

  always @(negedge clk) begin
    if (mon_en) begin
      automatic bit in_win = !mem_ce_n && !mem_we_n;
      if (!mem_ce_n && !mem_oe_n && mem_we_n) acc_cnt++; else acc_cnt = 0;
      if (prev_close) begin
        check(!mem_dq_oe, "R6 driver released", mem_dq_oe, 0);
      end
      prev_close = 1'b0;
      if (in_win) begin
        if (!prev_win) begin
          check(setup_len >= int'(P_AS), "R3 setup", setup_len, P_AS);
          win_len = 0;
        end else if (mem_dq_out != prev_dq || mem_addr != prev_addr) begin
          check(1'b0, "R6 data/addr stable in window", mem_dq_out, prev_dq);
        end
        if (!mem_oe_n || !mem_dq_oe) check(1'b0, "R5 oe high, driver on", mem_oe_n, 1);
        win_len++;
        prev_dq   = mem_dq_out;
        prev_addr = mem_addr;
      end else if (prev_win) begin
        check(win_len == int'(EXP_PW), "R3 window length", win_len, EXP_PW);
        check(mem_dq_oe && mem_ce_n, "R6 data held through rise", mem_dq_oe, 1);
        mem_m[int'(prev_addr)] = prev_dq;
        rec_active = 1;
        rec_len    = 0;
        prev_close = 1'b1;
      end
      if (rec_active) begin
        if (!mem_ce_n) begin
          check(rec_len >= int'(P_WR) + 1, "R7 recovery gap", rec_len, P_WR + 1);
          rec_active = 0;
        end else if (mem_we_n) begin
          rec_len++;
        end
      end
      if (!mem_ce_n && mem_we_n && mem_oe_n) setup_len++;
      else if (mem_ce_n) setup_len = 0;
      prev_win = in_win;
    end
  end

  task automatic do_op(input logic wr, input logic [AW-1:0] a, input logic [DW-1:0] d);
    int lat;
    bit busy_ok;
    logic [DW-1:0] rd_before;
    @(negedge clk);
    rd_before  = host_rdata;
    host_req   = 1'b1;
    host_we    = wr;
    host_addr  = a;
    host_wdata = d;
    @(posedge clk);
    #1;
    host_req = 1'b0;
    lat = 0;
    busy_ok = 1;
    while (!host_done && lat < 100) begin
      if (host_ready) busy_ok = 0;
      if (!wr && !mem_oe_n && (mem_addr != a || !mem_we_n || mem_ce_n))
        check(1'b0, "R1 read framing", mem_addr, a);
      @(posedge clk);
      #1;
      lat++;
    end
    check(busy_ok, "R8 ready low while busy", busy_ok, 1);
    if (wr) begin
      check(lat == int'(EXP_WLAT), "R7 write done latency", lat, EXP_WLAT);
      check(host_rdata == rd_before, "R9 rdata unchanged by write", host_rdata, rd_before);
      shadow[int'(a)] = d;
      check(mem_m.exists(int'(a)) && mem_m[int'(a)] == d, "R6 stored byte",
            model_rd(a), d);
    end else begin
      check(lat == int'(EXP_RD), "R2 read done latency", lat, EXP_RD);
      check(host_rdata == shadow[int'(a)], "R2 read data", host_rdata, shadow[int'(a)]);
    end
    @(posedge clk);
    #1;
    check(!host_done, "R9 done one cycle", host_done, 0);
    if (!wr) check(host_rdata == shadow[int'(a)], "R9 rdata held", host_rdata, shadow[int'(a)]);
  endtask

  initial begin
    host_req = 1'b0; host_we = 1'b0; host_addr = '0; host_wdata = '0;
    rst_n = 1'b0;
    repeat (3) @(posedge clk);
    #1;
    rst_n = 1'b1;
    repeat (3) @(posedge clk);
    #1;
    check(host_ready && !host_done && mem_ce_n && mem_we_n && mem_oe_n && !mem_dq_oe,
          "R10 reset state", {host_ready, host_done, mem_ce_n, mem_we_n, mem_oe_n, mem_dq_oe},
          6'b101110);
    mon_en = 1;

    for (int i = 0; i < NVEC; i++) begin
      do_op(VEC[i][21], VEC[i][20:8], VEC[i][7:0]);
    end

    // R4: address bus constant through a read while host address moves
    @(negedge clk);
    host_req = 1'b1; host_we = 1'b0; host_addr = 13'h0AAA;
    @(posedge clk);
    #1;
    host_we = 1'b1; host_addr = 13'h0200; host_wdata = 8'h77;
    begin
      int n = 0;
      while (!host_done && n < 100) begin
        check(mem_addr == 13'h0AAA, "R4 address held", mem_addr, 13'h0AAA);
        @(posedge clk);
        #1;
        n++;
      end
    end
    // R8: request held during busy must not have started a cycle
    host_req = 1'b0;
    check(host_rdata == shadow[32'h0AAA], "R8 held-off read result", host_rdata, shadow[32'h0AAA]);
    repeat (3) begin
      @(posedge clk);
      #1;
      check(mem_ce_n && host_ready, "R8 no cycle from held-off request", mem_ce_n, 1);
    end
    check(!mem_m.exists(32'h0200), "R8 memory untouched", model_rd(13'h0200), 0);

    // Back-to-back write then read at the top address
    do_op(1'b1, 13'h1FFF, 8'hC3);
    do_op(1'b0, 13'h1FFF, 8'h00);

    repeat (5) @(posedge clk);
    finish_sim();
  end
endmodule